// File: doc/BRIEF.md
# Bit-addressable memory operation unit

This unit carries out single-bit instructions against a 256-byte on-chip data memory. A bit address of 8 bits is split into a byte address and a bit index. Bit addresses with the top bit clear fall in a 16-byte window starting at byte 0x20. Bit addresses with the top bit set reach only those bytes whose address is a multiple of eight. The unit talks to the memory through one byte port with a read strobe and a write strobe. The memory returns read data on the clock after the read strobe.

Operations that modify memory always read the whole byte first. They change the selected bit and write the byte back, so the other seven bits keep their values. Operations that feed the carry only read the byte, and so do the bit-test jumps. The carry flag lives in this unit and is exported so that it can be merged into bit 7 of the status word. A `jump_taken` output tells the sequencer whether a conditional jump on the bit should be taken.

The controller has four states. ST_IDLE waits for `start`. ST_READ drives the read strobe. In ST_EVAL the returned byte is used: the carry, the jump flag and the new byte are captured here. ST_WRITE drives the write strobe. The transitions are: ST_IDLE→ST_READ on `start`; ST_READ→ST_EVAL always; ST_EVAL→ST_WRITE when the operation must write; ST_EVAL→ST_IDLE otherwise; ST_WRITE→ST_IDLE always.

Top module: `bitop_unit`

## Requirements
- R1: After reset, `busy`, `done`, `carry`, `jump_taken`, `mem_rd` and `mem_wr` are all 0.
- R2: A bit address below 0x80 selects byte 0x20 + bit_addr[6:3] and bit index bit_addr[2:0]. For example, 0x00 selects byte 0x20 bit 0, and 0x7F selects byte 0x2F bit 7.
- R3: A bit address of 0x80 or above selects byte {bit_addr[7:3],3'b000} and bit index bit_addr[2:0]. For example, 0x80 selects byte 0x80 bit 0, and 0xFF selects byte 0xF8 bit 7.
- R4: Op 0 sets the selected bit, op 1 clears it and op 2 inverts it. Each writes the byte back with the other seven bits unchanged.
- R5: Op 3 copies the selected bit into the carry. Op 4 writes the carry into the selected bit, leaving the other bits unchanged.
- R6: Op 5 makes carry = carry AND bit, op 6 carry AND NOT bit, op 7 carry OR bit and op 8 carry OR NOT bit. None of these writes memory.
- R7: Op 9 (test-and-clear) sets `jump_taken` to the value of the bit. When the bit is 1 it also clears the bit. When the bit is 0 it does not write.
- R8: Op 10 reports `jump_taken` = bit and op 11 reports `jump_taken` = NOT bit. Neither writes memory nor changes the carry. Every op other than 9, 10 and 11 reports `jump_taken` = 0.
- R9: `busy` rises on the clock after `start`, and `mem_rd` is high in that first busy cycle. A writing op is busy for 3 cycles, with `mem_wr` in the third cycle at the same address. A non-writing op is busy for 2 cycles. `done` pulses for one cycle as `busy` falls, and `carry` and `jump_taken` are valid from then on.
- R10: Op codes 12 to 15 neither write memory nor change the carry, and they report `jump_taken` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op | input | 4 | Operation code |
| bit_addr | input | 8 | Bit address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| carry | output | 1 | Carry flag |
| jump_taken | output | 1 | Jump condition result of the last op |
| mem_addr | output | 8 | Byte address to memory |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Read data, valid one clock after `mem_rd` |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Write data |

## Verification
A wrong latched byte address or bit index shows up in the memory image at the ST_WRITE cycle. It also shows up as a wrong carry or jump result at the `done` pulse, three clocks after `start` at the latest. A stray transition out of ST_EVAL shows up at once: it either adds a write cycle or drops one, which is visible as a busy length of 3 where 2 was due, or the reverse, and as a corrupted byte. Because the carry persists between operations, a wrong carry update also spreads into every later carry-combining result. For that reason, every operation is compared against a model of both memory and carry.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    typedef enum logic [3:0] {
        OP_SET   = 4'd0,
        OP_CLR   = 4'd1,
        OP_CPL   = 4'd2,
        OP_TOC   = 4'd3,
        OP_FROMC = 4'd4,
        OP_ANDC  = 4'd5,
        OP_ANDNC = 4'd6,
        OP_ORC   = 4'd7,
        OP_ORNC  = 4'd8,
        OP_JBC   = 4'd9,
        OP_JB    = 4'd10,
        OP_JNB   = 4'd11
    } bit_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_EVAL,
        ST_WRITE
    } bop_state_e;

endpackage

// File: rtl/bitop_addr_map.sv
module bitop_addr_map #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] LOW_BASE = 'h20,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [ADDR_W-1:0] bit_addr,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [IDX_W-1:0]  bit_idx
);
    localparam int LOW_FIELD_W = ADDR_W - 1 - IDX_W;

    logic [LOW_FIELD_W-1:0] low_field;
    logic [ADDR_W-1:0]      low_byte;
    logic [ADDR_W-1:0]      high_byte;

    // Lower half: byte window above LOW_BASE; upper half: aligned registers.
    always_comb begin
        low_field = bit_addr[ADDR_W-2:IDX_W];
        low_byte  = LOW_BASE + ADDR_W'(low_field);
        high_byte = {bit_addr[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
        byte_addr = bit_addr[ADDR_W-1] ? high_byte : low_byte;
        bit_idx   = bit_addr[IDX_W-1:0];
    end

endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  bit_op_e           op,
    input  logic [DATA_W-1:0] rdata,
    input  logic [IDX_W-1:0]  idx,
    input  logic              carry_in,
    output logic [DATA_W-1:0] wdata,
    output logic              carry_out,
    output logic              wr_need,
    output logic              jump
);
    logic cur;
    logic new_bit;

    always_comb begin
        cur       = rdata[idx];
        new_bit   = cur;
        carry_out = carry_in;
        wr_need   = 1'b0;
        jump      = 1'b0;
        case (op)
            OP_SET:   begin new_bit = 1'b1;     wr_need = 1'b1; end
            OP_CLR:   begin new_bit = 1'b0;     wr_need = 1'b1; end
            OP_CPL:   begin new_bit = ~cur;     wr_need = 1'b1; end
            OP_TOC:   carry_out = cur;
            OP_FROMC: begin new_bit = carry_in; wr_need = 1'b1; end
            OP_ANDC:  carry_out = carry_in & cur;
            OP_ANDNC: carry_out = carry_in & ~cur;
            OP_ORC:   carry_out = carry_in | cur;
            OP_ORNC:  carry_out = carry_in | ~cur;
            OP_JBC:   begin jump = cur; new_bit = 1'b0; wr_need = cur; end
            OP_JB:    jump = cur;
            OP_JNB:   jump = ~cur;
            default:  ;
        endcase
    end

    // Merge the single changed bit back into the byte.
    for (genvar g = 0; g < DATA_W; g++) begin : g_merge
        assign wdata[g] = (idx == IDX_W'(g)) ? new_bit : rdata[g];
    end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] LOW_BASE = 'h20,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        op,
    input  logic [ADDR_W-1:0] bit_addr,
    output logic              busy,
    output logic              done,
    output logic              carry,
    output logic              jump_taken,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata
);
    bop_state_e        state, state_nx;
    bit_op_e           op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] wbyte_q;
    logic              carry_q, jump_q, done_q;

    logic [ADDR_W-1:0] map_byte;
    logic [IDX_W-1:0]  map_idx;
    logic [DATA_W-1:0] alu_wdata;
    logic              alu_carry, alu_wr, alu_jump;

    bitop_addr_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOW_BASE(LOW_BASE)) u_map (
        .bit_addr  (bit_addr),
        .byte_addr (map_byte),
        .bit_idx   (map_idx)
    );

    bitop_alu #(.DATA_W(DATA_W)) u_alu (
        .op        (op_q),
        .rdata     (mem_rdata),
        .idx       (idx_q),
        .carry_in  (carry_q),
        .wdata     (alu_wdata),
        .carry_out (alu_carry),
        .wr_need   (alu_wr),
        .jump      (alu_jump)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_READ;
            ST_READ:  state_nx = ST_EVAL;
            ST_EVAL:  state_nx = alu_wr ? ST_WRITE : ST_IDLE;
            ST_WRITE: state_nx = ST_IDLE;
        endcase
    end

    // Operand latch and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_SET;
            addr_q  <= '0;
            idx_q   <= '0;
            wbyte_q <= '0;
            carry_q <= 1'b0;
            jump_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= ((state == ST_EVAL) && !alu_wr) || (state == ST_WRITE);
            if (state == ST_IDLE && start) begin
                op_q   <= bit_op_e'(op);
                addr_q <= map_byte;
                idx_q  <= map_idx;
                jump_q <= 1'b0;
            end
            if (state == ST_EVAL) begin
                wbyte_q <= alu_wdata;
                carry_q <= alu_carry;
                jump_q  <= alu_jump;
            end
        end
    end

    // Outputs
    always_comb begin
        busy       = (state != ST_IDLE);
        mem_rd     = (state == ST_READ);
        mem_wr     = (state == ST_WRITE);
        mem_addr   = addr_q;
        mem_wdata  = wbyte_q;
        done       = done_q;
        carry      = carry_q;
        jump_taken = jump_q;
    end

endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              carry,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [3:0]        op_q
);
    logic [1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= (run_q == 2'd3) ? run_q : run_q + 2'd1;
        else           run_q <= '0;
    end

    a_r9_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd, 2));

    a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $stable(mem_addr));

    a_r9_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_q <= 2'd2);

    a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    a_r4_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $countones(mem_wdata ^ $past(mem_rdata)) <= 1);

    a_r6_no_write_carry_ops: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> !(op_q inside {4'd3, 4'd5, 4'd6, 4'd7, 4'd8}));

    a_r10_no_write_unused: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> !(op_q inside {4'd10, 4'd11, 4'd12, 4'd13, 4'd14, 4'd15}));

    a_r5_carry_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(carry) |-> (done || mem_wr));

endmodule

bind bitop_unit bitop_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .carry     (carry),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata),
    .op_q      (op_q)
);

// File: tb/tb_bitop_unit.sv
module tb_bitop_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] op = '0;
    logic [7:0] bit_addr = '0;
    logic       busy, done, carry, jump_taken, mem_rd, mem_wr;
    logic [7:0] mem_addr, mem_rdata, mem_wdata;

    logic [7:0] mem [256];
    logic [7:0] model [256];
    logic       model_c = 1'b0;
    logic       tb_wr = 1'b0;
    logic [7:0] tb_waddr = '0, tb_wdata = '0;
    int         n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitop_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .bit_addr(bit_addr),
        .busy(busy), .done(done), .carry(carry), .jump_taken(jump_taken),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata)
    );

    // Test memory: one-clock read latency.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr];
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        else if (tb_wr) mem[tb_waddr] <= tb_wdata;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] map_byte(input logic [7:0] ba);
        return ba[7] ? {ba[7:3], 3'b000} : 8'h20 + {4'b0, ba[6:3]};
    endfunction

    task automatic poke(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        tb_wr = 1'b1; tb_waddr = a; tb_wdata = d;
        @(negedge clk);
        tb_wr = 1'b0;
        model[a] = d;
    endtask

    task automatic run_op(input logic [3:0] o, input logic [7:0] ba);
        logic [7:0] b, nb;
        logic [2:0] ix;
        logic cur, ec, ej, ew;
        int cyc;
        b = map_byte(ba); ix = ba[2:0]; nb = model[b]; cur = nb[ix];
        ec = model_c; ej = 1'b0; ew = 1'b0;
        case (o)
            4'd0: begin nb[ix] = 1'b1; ew = 1'b1; end
            4'd1: begin nb[ix] = 1'b0; ew = 1'b1; end
            4'd2: begin nb[ix] = ~cur; ew = 1'b1; end
            4'd3: ec = cur;
            4'd4: begin nb[ix] = model_c; ew = 1'b1; end
            4'd5: ec = model_c & cur;
            4'd6: ec = model_c & ~cur;
            4'd7: ec = model_c | cur;
            4'd8: ec = model_c | ~cur;
            4'd9: begin ej = cur; if (cur) begin nb[ix] = 1'b0; ew = 1'b1; end end
            4'd10: ej = cur;
            4'd11: ej = ~cur;
            default: ;
        endcase
        @(negedge clk);
        start = 1'b1; op = o; bit_addr = ba;
        @(negedge clk);
        start = 1'b0;
        check(busy && mem_rd, "R9 busy+read in first cycle", {busy, mem_rd}, 3);
        cyc = 0;
        while (!done && cyc < 8) begin
            if (busy) cyc++;
            @(negedge clk);
        end
        model[b] = nb; model_c = ec;
        check(cyc == (ew ? 3 : 2), "R9 busy length", cyc, ew ? 3 : 2);
        check(carry == ec, $sformatf("R5/R6 carry op%0d", o), carry, ec);
        check(jump_taken == ej, $sformatf("R7/R8 jump op%0d", o), jump_taken, ej);
        check(mem[b] == nb, $sformatf("R4 target byte op%0d addr%0h", o, b), mem[b], nb);
        begin
            int diffs = 0;
            for (int i = 0; i < 256; i++) if (mem[i] !== model[i]) diffs++;
            check(diffs == 0, $sformatf("R10 memory image op%0d", o), diffs, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4051));
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        check(!busy && !done && !carry && !jump_taken && !mem_rd && !mem_wr,
              "R1 reset outputs", {busy, done, carry, jump_taken, mem_rd, mem_wr}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 256; i++) poke(8'(i), 8'($urandom));

        // R2 low-half mapping corners
        poke(8'h20, 8'h00); run_op(4'd0, 8'h00);
        check(mem[8'h20] == 8'h01, "R2 0x00 -> byte20 bit0", mem[8'h20], 8'h01);
        poke(8'h2F, 8'h00); run_op(4'd0, 8'h7F);
        check(mem[8'h2F] == 8'h80, "R2 0x7F -> byte2F bit7", mem[8'h2F], 8'h80);
        // R3 high-half mapping corners
        poke(8'h80, 8'hFF); run_op(4'd1, 8'h80);
        check(mem[8'h80] == 8'hFE, "R3 0x80 -> byte80 bit0", mem[8'h80], 8'hFE);
        poke(8'hF8, 8'h00); run_op(4'd2, 8'hFF);
        check(mem[8'hF8] == 8'h80, "R3 0xFF -> byteF8 bit7", mem[8'hF8], 8'h80);
        // R5 carry moves
        poke(8'hD0, 8'h80); run_op(4'd3, 8'hD7);
        check(carry == 1'b1, "R5 bit to carry", carry, 1);
        poke(8'h21, 8'h00); run_op(4'd4, 8'h0B);
        check(mem[8'h21] == 8'h08, "R5 carry to bit", mem[8'h21], 8'h08);
        // R6 inverted AND/OR
        run_op(4'd6, 8'h0B); run_op(4'd8, 8'h08);
        // R7 test-and-clear both outcomes
        poke(8'h22, 8'h04); run_op(4'd9, 8'h12);
        check(mem[8'h22] == 8'h00 && jump_taken, "R7 jbc taken", mem[8'h22], 0);
        run_op(4'd9, 8'h12);
        check(!jump_taken, "R7 jbc not taken", jump_taken, 0);
        // R8 jumps on bit
        run_op(4'd10, 8'h12); run_op(4'd11, 8'h12);
        // R10 unused codes
        run_op(4'd12, 8'h40); run_op(4'd15, 8'hC3);

        for (int k = 0; k < 400; k++) run_op(4'($urandom_range(15, 0)), 8'($urandom));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule